// File: doc/BRIEF.md
# Drive Task-File Register Front End

This block sits between a host register bus and the command engine of an ATA/ATAPI-style drive controller. It decodes single-cycle reads and writes on a small offset space. It holds the parameter registers that the host loads before issuing a command: feature, sector count, three address bytes and device select. It also holds a device-control byte, a generic scratch word and the latched opcode.

Parameter writes are accepted only while the drive reports itself idle. A command write hands the opcode to the engine as a one-cycle strobe. Several offsets behave asymmetrically: a read returns drive-supplied state rather than what was written. The data port passes 16-bit transfers straight through to the PIO data path.

The block also owns the pending-interrupt flag. The command engine raises it. A status read or an accepted command lowers it, and the device-control mask gates what reaches the host.

Top module: `taskfile_front`

## Requirements
- R1: Writes to offsets 1 (feature), 2 (count), 3 (LBA byte 0), 4 (LBA byte 1), 5 (LBA byte 2) and 6 (device) change nothing while drvStatus bit 7 (busy) or bit 3 (data request) is 1. They are accepted only when both bits are 0.
- R2: An accepted parameter write stores busWdata[7:0] only; the stored byte appears on the matching task* output after the clock edge of the write.
- R3: A write to offset 7 while writable raises cmdStrobe for exactly the next cycle with cmdOpcode equal to busWdata[7:0], and clears the pending interrupt. While not writable it produces no strobe and leaves the interrupt pending.
- R4: A read at offset 7 returns {8'h00, drvStatus} and clears the pending interrupt at the end of that cycle.
- R5: A read at offset 8 returns the same status without touching the pending interrupt. A write at offset 8 stores busWdata[7:0] into devCtl whatever the drive status.
- R6: A read at offset 1 returns drvError, and a read at offset 3 returns drvAux (both zero-extended), never the written feature or LBA byte 0.
- R7: Reads at offsets 2, 4, 5 and 6 return the stored count, LBA byte 1, LBA byte 2 and device bytes, zero-extended.
- R8: An access at offset 0 is a 16-bit data-port transfer and is never gated by status. A read asserts pioRdStb for that cycle and returns pioRdata. A write asserts pioWrStb for that cycle with pioWdata equal to busWdata.
- R9: driveIrq equals the pending flag ANDed with the inverse of devCtl bit 1 (interrupt disable). intSet sets the flag on the next edge and wins over a clear in the same cycle.
- R10: Writes to any offset from 9 upward store the full 16-bit word into one scratch register. A read at any such offset returns it.
- R11: After reset every stored register is 0, driveIrq and cmdStrobe are 0, and busRdata is 0 while busSel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational |
| drvStatus | input | 8 | Drive status byte |
| drvError | input | 8 | Drive error byte |
| drvAux | input | 8 | Drive byte returned at offset 3 |
| intSet | input | 1 | Engine raises pending interrupt |
| pioRdata | input | 16 | PIO read data |
| pioRdStb | output | 1 | PIO read strobe |
| pioWrStb | output | 1 | PIO write strobe |
| pioWdata | output | 16 | PIO write data |
| cmdStrobe | output | 1 | One-cycle command issue |
| cmdOpcode | output | 8 | Latched opcode |
| taskFeature | output | 8 | Feature byte |
| taskCount | output | 8 | Sector count byte |
| taskLba0 | output | 8 | LBA byte 0 |
| taskLba1 | output | 8 | LBA byte 1 |
| taskLba2 | output | 8 | LBA byte 2 |
| taskDevice | output | 8 | Device select byte |
| devCtl | output | 8 | Device-control byte |
| driveIrq | output | 1 | Interrupt to host |

## Verification
The hardest situation to reach is a set and a clear landing on the same edge. The engine raises intSet in exactly the cycle the host reads status or issues a command, and the flag must survive. The bench reaches it by carrying an intSet value inside each bus access, so the collision is driven on one chosen edge. The gate is also swept over all 256 status values, so every combination of the busy and data-request bits is attempted against a parameter write and a command write.

// File: rtl/tf_pkg.sv
package tf_pkg;

  localparam int OFS_DATA  = 0;
  localparam int OFS_FEAT  = 1;
  localparam int OFS_COUNT = 2;
  localparam int OFS_LBA0  = 3;
  localparam int OFS_LBA1  = 4;
  localparam int OFS_LBA2  = 5;
  localparam int OFS_DEV   = 6;
  localparam int OFS_CMD   = 7;
  localparam int OFS_ALT   = 8;

  localparam int BSY_BIT  = 7;
  localparam int DRQ_BIT  = 3;
  localparam int NIEN_BIT = 1;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_ERR, RD_COUNT, RD_AUX,
    RD_LBA1, RD_LBA2, RD_DEV, RD_STATUS, RD_SCRATCH
  } rdSel_e;

  typedef struct packed {
    logic   wrFeat;
    logic   wrCount;
    logic   wrLba0;
    logic   wrLba1;
    logic   wrLba2;
    logic   wrDev;
    logic   wrCmd;
    logic   wrDevCtl;
    logic   wrScratch;
    rdSel_e rdSel;
  } tfCtrl_t;

endpackage

// File: rtl/tf_ctrl.sv
module tf_ctrl
  import tf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] drvStatus,
  input  logic              intSet,
  output tfCtrl_t           ctrl,
  output logic              pioRdStb,
  output logic              pioWrStb,
  output logic              cmdStrobe,
  output logic              irqPending
);

  logic writable;
  logic isWr;
  logic isRd;
  logic irqClear;
  int   ofs;

  assign writable = ~drvStatus[BSY_BIT] & ~drvStatus[DRQ_BIT];
  assign isWr     = busSel & busWr;
  assign isRd     = busSel & ~busWr;
  assign ofs      = int'(busAddr);

  always_comb begin
    ctrl = '0;
    ctrl.rdSel = RD_NONE;
    pioRdStb = 1'b0;
    pioWrStb = 1'b0;
    if (isWr) begin
      case (ofs)
        OFS_DATA:  pioWrStb       = 1'b1;
        OFS_FEAT:  ctrl.wrFeat    = writable;
        OFS_COUNT: ctrl.wrCount   = writable;
        OFS_LBA0:  ctrl.wrLba0    = writable;
        OFS_LBA1:  ctrl.wrLba1    = writable;
        OFS_LBA2:  ctrl.wrLba2    = writable;
        OFS_DEV:   ctrl.wrDev     = writable;
        OFS_CMD:   ctrl.wrCmd     = writable;
        OFS_ALT:   ctrl.wrDevCtl  = 1'b1;
        default:   ctrl.wrScratch = 1'b1;
      endcase
    end else if (isRd) begin
      case (ofs)
        OFS_DATA: begin
          pioRdStb   = 1'b1;
          ctrl.rdSel = RD_DATA;
        end
        OFS_FEAT:  ctrl.rdSel = RD_ERR;
        OFS_COUNT: ctrl.rdSel = RD_COUNT;
        OFS_LBA0:  ctrl.rdSel = RD_AUX;
        OFS_LBA1:  ctrl.rdSel = RD_LBA1;
        OFS_LBA2:  ctrl.rdSel = RD_LBA2;
        OFS_DEV:   ctrl.rdSel = RD_DEV;
        OFS_CMD:   ctrl.rdSel = RD_STATUS;
        OFS_ALT:   ctrl.rdSel = RD_STATUS;
        default:   ctrl.rdSel = RD_SCRATCH;
      endcase
    end
  end

  // Status read at the command offset, or an accepted command, drops the flag.
  assign irqClear = ctrl.wrCmd | (isRd && ofs == OFS_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
      cmdStrobe  <= 1'b0;
    end else begin
      cmdStrobe <= ctrl.wrCmd;
      if (intSet) irqPending <= 1'b1;
      else if (irqClear) irqPending <= 1'b0;
    end
  end

  a_r3_strobe_from_cmd: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(isWr && ofs == OFS_CMD && writable));

  a_r1_no_gated_param_write: assert property (@(posedge clk) disable iff (!rstN)
    !writable |-> !(ctrl.wrFeat || ctrl.wrCount || ctrl.wrLba0 || ctrl.wrLba1
                    || ctrl.wrLba2 || ctrl.wrDev || ctrl.wrCmd));

  a_r8_pio_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pioRdStb && pioWrStb));

endmodule

// File: rtl/tf_dpath.sv
module tf_dpath
  import tf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tfCtrl_t           ctrl,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] drvStatus,
  input  logic [BYTE_W-1:0] drvError,
  input  logic [BYTE_W-1:0] drvAux,
  input  logic [DATA_W-1:0] pioRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [BYTE_W-1:0] taskFeature,
  output logic [BYTE_W-1:0] taskCount,
  output logic [BYTE_W-1:0] taskLba0,
  output logic [BYTE_W-1:0] taskLba1,
  output logic [BYTE_W-1:0] taskLba2,
  output logic [BYTE_W-1:0] taskDevice,
  output logic [BYTE_W-1:0] cmdOpcode,
  output logic [BYTE_W-1:0] devCtl
);

  localparam int PAD_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] wrByte;
  logic [DATA_W-1:0] scratch;

  assign wrByte = busWdata[BYTE_W-1:0];

  function automatic logic [DATA_W-1:0] widen(input logic [BYTE_W-1:0] b);
    return {{PAD_W{1'b0}}, b};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taskFeature <= '0;
      taskCount   <= '0;
      taskLba0    <= '0;
      taskLba1    <= '0;
      taskLba2    <= '0;
      taskDevice  <= '0;
      cmdOpcode   <= '0;
      devCtl      <= '0;
      scratch     <= '0;
    end else begin
      if (ctrl.wrFeat)    taskFeature <= wrByte;
      if (ctrl.wrCount)   taskCount   <= wrByte;
      if (ctrl.wrLba0)    taskLba0    <= wrByte;
      if (ctrl.wrLba1)    taskLba1    <= wrByte;
      if (ctrl.wrLba2)    taskLba2    <= wrByte;
      if (ctrl.wrDev)     taskDevice  <= wrByte;
      if (ctrl.wrCmd)     cmdOpcode   <= wrByte;
      if (ctrl.wrDevCtl)  devCtl      <= wrByte;
      if (ctrl.wrScratch) scratch     <= busWdata;
    end
  end

  always_comb begin
    case (ctrl.rdSel)
      RD_DATA:    busRdata = pioRdata;
      RD_ERR:     busRdata = widen(drvError);
      RD_COUNT:   busRdata = widen(taskCount);
      RD_AUX:     busRdata = widen(drvAux);
      RD_LBA1:    busRdata = widen(taskLba1);
      RD_LBA2:    busRdata = widen(taskLba2);
      RD_DEV:     busRdata = widen(taskDevice);
      RD_STATUS:  busRdata = widen(drvStatus);
      RD_SCRATCH: busRdata = scratch;
      default:    busRdata = '0;
    endcase
  end

  a_r10_scratch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wrScratch |=> $stable(scratch));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wrCount |=> $stable(taskCount));

endmodule

// File: rtl/taskfile_front.sv
module taskfile_front
  import tf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [BYTE_W-1:0] drvStatus,
  input  logic [BYTE_W-1:0] drvError,
  input  logic [BYTE_W-1:0] drvAux,
  input  logic              intSet,
  input  logic [DATA_W-1:0] pioRdata,
  output logic              pioRdStb,
  output logic              pioWrStb,
  output logic [DATA_W-1:0] pioWdata,
  output logic              cmdStrobe,
  output logic [BYTE_W-1:0] cmdOpcode,
  output logic [BYTE_W-1:0] taskFeature,
  output logic [BYTE_W-1:0] taskCount,
  output logic [BYTE_W-1:0] taskLba0,
  output logic [BYTE_W-1:0] taskLba1,
  output logic [BYTE_W-1:0] taskLba2,
  output logic [BYTE_W-1:0] taskDevice,
  output logic [BYTE_W-1:0] devCtl,
  output logic              driveIrq
);

  tfCtrl_t ctrl;
  logic    irqPending;

  tf_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .drvStatus(drvStatus), .intSet(intSet), .ctrl(ctrl), .pioRdStb(pioRdStb),
    .pioWrStb(pioWrStb), .cmdStrobe(cmdStrobe), .irqPending(irqPending)
  );

  tf_dpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busWdata(busWdata),
    .drvStatus(drvStatus), .drvError(drvError), .drvAux(drvAux),
    .pioRdata(pioRdata), .busRdata(busRdata), .taskFeature(taskFeature),
    .taskCount(taskCount), .taskLba0(taskLba0), .taskLba1(taskLba1),
    .taskLba2(taskLba2), .taskDevice(taskDevice), .cmdOpcode(cmdOpcode),
    .devCtl(devCtl)
  );

  assign pioWdata = busWdata;
  assign driveIrq = irqPending & ~devCtl[NIEN_BIT];

  logic busyNow;
  assign busyNow = drvStatus[BSY_BIT] | drvStatus[DRQ_BIT];

  a_r1_busy_keeps_params: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busyNow) |=> ($stable(taskFeature) && $stable(taskCount)
      && $stable(taskLba0) && $stable(taskLba1) && $stable(taskLba2)
      && $stable(taskDevice) && !cmdStrobe));

  a_r4_status_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && int'(busAddr) == OFS_CMD && !intSet) |=> !driveIrq);

  a_r5_alt_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && int'(busAddr) == OFS_ALT && driveIrq) |=> driveIrq);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (intSet && !(busSel && busWr && int'(busAddr) == OFS_ALT))
      |=> (driveIrq == ~devCtl[NIEN_BIT]));

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (busRdata == '0));

endmodule

// File: tb/sim_taskfile_front.sv
module sim_taskfile_front;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, intSet = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0, pioRdata = 16'hBEEF;
  logic [7:0]  drvStatus = '0, drvError = 8'h5A, drvAux = 8'hC3;
  logic [15:0] busRdata, pioWdata;
  logic        pioRdStb, pioWrStb, cmdStrobe, driveIrq;
  logic [7:0]  cmdOpcode, taskFeature, taskCount, taskLba0, taskLba1, taskLba2,
               taskDevice, devCtl;

  int nRun = 0, nFail = 0;
  logic [15:0] rd;
  logic        sRd, sWr;

  always #(CLK_PERIOD/2) clk = ~clk;

  taskfile_front u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample combinational outputs, then edge.
  task automatic acc(input logic wr, input int a, input logic [15:0] d, input logic setI);
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = 4'(a); busWdata = d; intSet = setI;
    #1;
    rd = busRdata; sRd = pioRdStb; sWr = pioWrStb;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0; intSet = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFail++;
    $display("FAIL watchdog expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] expCount, expLba1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle();
    // R11 reset state
    check("R11 count", taskCount, 0);
    check("R11 devctl", devCtl, 0);
    check("R11 irq", driveIrq, 0);
    check("R11 strobe", cmdStrobe, 0);
    check("R11 idle rdata", busRdata, 0);

    // R1/R2 sweep every status value against count and lba1 writes
    expCount = 0; expLba1 = 0;
    for (int s = 0; s < 256; s++) begin
      logic ok;
      drvStatus = 8'(s);
      ok = (s[7] == 1'b0) && (s[3] == 1'b0);
      acc(1'b1, 2, {8'(s ^ 8'hFF), 8'(s ^ 8'hA5)}, 1'b0);
      if (ok) expCount = 8'(s ^ 8'hA5);
      check("R1 R2 count gate", taskCount, expCount);
      acc(1'b1, 4, {8'h77, 8'(s + 3)}, 1'b0);
      if (ok) expLba1 = 8'(s + 3);
      check("R1 lba1 gate", taskLba1, expLba1);
      acc(1'b1, 7, 16'h00EC, 1'b0);
      check("R3 strobe gate", cmdStrobe, ok);
      if (ok) check("R3 opcode", cmdOpcode, 8'hEC);
      idle();
      check("R3 strobe one cycle", cmdStrobe, 0);
    end

    // R2/R7 remaining parameter registers while writable
    drvStatus = 8'h40;
    acc(1'b1, 1, 16'hAB12, 1'b0); check("R2 feature", taskFeature, 8'h12);
    acc(1'b1, 3, 16'hCD34, 1'b0); check("R2 lba0", taskLba0, 8'h34);
    acc(1'b1, 5, 16'hEF56, 1'b0); check("R2 lba2", taskLba2, 8'h56);
    acc(1'b1, 6, 16'h01E0, 1'b0); check("R2 device", taskDevice, 8'hE0);
    acc(1'b0, 2, 0, 1'b0); check("R7 count read", rd, {8'h00, expCount});
    acc(1'b0, 4, 0, 1'b0); check("R7 lba1 read", rd, {8'h00, expLba1});
    acc(1'b0, 5, 0, 1'b0); check("R7 lba2 read", rd, 16'h0056);
    acc(1'b0, 6, 0, 1'b0); check("R7 device read", rd, 16'h00E0);
    // R6 asymmetric reads
    acc(1'b0, 1, 0, 1'b0); check("R6 error read", rd, 16'h005A);
    acc(1'b0, 3, 0, 1'b0); check("R6 aux read", rd, 16'h00C3);
    // R1 feature gated by DRQ
    drvStatus = 8'h08;
    acc(1'b1, 1, 16'h0099, 1'b0); check("R1 feature drq", taskFeature, 8'h12);
    drvStatus = 8'h40;

    // R8 data port, never gated
    drvStatus = 8'h88;
    acc(1'b0, 0, 0, 1'b0);
    check("R8 pio read data", rd, 16'hBEEF); check("R8 rd strobe", sRd, 1);
    acc(1'b1, 0, 16'h1234, 1'b0);
    check("R8 wr strobe", sWr, 1);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = 0; busWdata = 16'hA55A; #1;
    check("R8 pio wdata", pioWdata, 16'hA55A);
    @(posedge clk); #1 busSel = 0;
    drvStatus = 8'h40;

    // R10 scratch at every upper offset
    for (int a = 9; a < 16; a++) begin
      acc(1'b1, a, 16'(a * 16'h1111), 1'b0);
      for (int b = 9; b < 16; b++) begin
        acc(1'b0, b, 0, 1'b0);
        check("R10 scratch", rd, 16'(a * 16'h1111));
      end
    end

    // R9/R4/R5 interrupt behaviour
    acc(1'b1, 0, 0, 1'b1); check("R9 set", driveIrq, 1);
    acc(1'b0, 8, 0, 1'b0);
    check("R5 alt status", rd, 16'h0040); check("R5 alt keeps", driveIrq, 1);
    acc(1'b0, 7, 0, 1'b0);
    check("R4 status", rd, 16'h0040); check("R4 clear", driveIrq, 0);
    acc(1'b0, 7, 0, 1'b1); check("R9 set wins over read", driveIrq, 1);
    acc(1'b1, 8, 16'h0002, 1'b0);
    check("R5 devctl", devCtl, 8'h02); check("R9 masked", driveIrq, 0);
    acc(1'b1, 8, 16'hFF00, 1'b0); check("R9 unmasked", driveIrq, 1);
    drvStatus = 8'h80;
    acc(1'b1, 8, 16'h0006, 1'b0); check("R5 devctl busy", devCtl, 8'h06);
    acc(1'b1, 8, 16'h0000, 1'b0);
    acc(1'b1, 7, 16'h00A0, 1'b0);
    check("R3 busy no strobe", cmdStrobe, 0); check("R3 busy irq kept", driveIrq, 1);
    drvStatus = 8'h00;
    acc(1'b1, 7, 16'h00A1, 1'b0);
    check("R3 cmd clears irq", driveIrq, 0); check("R3 cmd strobe", cmdStrobe, 1);
    check("R3 cmd opcode", cmdOpcode, 8'hA1);
    acc(1'b1, 7, 16'h00A2, 1'b1); check("R9 set wins over cmd", driveIrq, 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule